// File: doc/BRIEF.md
# Multi-Thread Time-Aware Gate Scheduler

This block drives the egress transmission gates of a switch from one shared linear table of timeslots. Up to eight execution threads each own a contiguous slice of that table, given by an entry address and an end index. A thread walks its slice forever: it holds each timeslot for that slot's duration, counted in delta units, and after the end index it returns to the entry address. Each timeslot names the ports it applies to, an enable flag, and an eight-bit mask of traffic classes whose gates stay closed. The result is one closed-gate mask per port and traffic class.

All threads share one operational base time. Thread i waits until the external time counter reaches the base time plus its own offset in nominal delta units, and it joins on the first delta boundary at or after that point. A delta unit is nominally `NOM_TICKS` clocks long. A signed drift correction input stretches or shrinks it by a whole number of ticks. That correction is clamped to plus or minus `MAX_ADJ` and is sampled only at engine start and once every `CORR_DELTAS` deltas. Software programs the table and the thread settings while the engine is stopped. It then issues a start command and later a stop command.

Top module: `gsched_top`

## Requirements
- R1: After reset every gate-closed output bit is 0, `stopped_o` is 1, `started_o` is 0 and `wr_err_o` is 0.
- R2: A start command taken while stopped clears `stopped_o` on the next clock. `started_o` rises on the clock at which `time_i` is sampled at or above the base time. The first delta boundary falls on that same clock. Both status bits are never 1 together.
- R3: One delta unit lasts `NOM_TICKS + clamp(adj_i)` clocks, where `adj_i` is two's complement and is clamped to the range -`MAX_ADJ`..+`MAX_ADJ`. The value is sampled at the start boundary and again every `CORR_DELTAS` boundaries.
- R4: Thread i runs only if i <= `glb_last_i`, the number of active threads minus one. It becomes active on the first delta boundary at which `time_i` >= base + offset_i * `NOM_TICKS`.
- R5: An active thread first holds the timeslot at its entry address. It keeps each timeslot for that slot's duration in deltas, and a duration of 0 counts as 1. It then moves to the next address, and after its end index it goes back to its entry address.
- R6: Output bit p*8+c is bit c of the closed mask of the current timeslot of an active thread whose timeslot is enabled and has port bit p set. It is 0 when no such thread exists. The outputs change one clock after the thread state moves.
- R7: A stop command sets every gate-closed bit to 0, sets `stopped_o` to 1 and clears `started_o` on the next clock, and all threads go idle. Stop wins over a start given in the same cycle.
- R8: A table, thread or global write made while the engine is not stopped is ignored and sets `wr_err_o`. The flag stays set until a start command is taken while stopped.
- R9: Writes made while the engine is stopped take effect for the next run.
- R10: When several active threads drive the same port, the lowest-numbered thread supplies that port's mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_i | input | TIME_W | Free-running time counter in ticks |
| adj_i | input | ADJ_W | Signed drift correction in ticks per delta |
| start_i | input | 1 | Start command |
| stop_i | input | 1 | Stop command |
| tbl_we_i | input | 1 | Timeslot write strobe |
| tbl_addr_i | input | IDX_W | Timeslot address |
| tbl_dur_i | input | DUR_W | Timeslot duration in deltas |
| tbl_ports_i | input | N_PORT | Ports the timeslot applies to |
| tbl_en_i | input | 1 | Timeslot enable |
| tbl_closed_i | input | 8 | Traffic classes held closed |
| thr_we_i | input | 1 | Thread setting write strobe |
| thr_sel_i | input | THR_W | Thread number |
| thr_entry_i | input | IDX_W | Thread entry address |
| thr_end_i | input | IDX_W | Thread end index |
| thr_off_i | input | OFF_W | Thread start offset in nominal deltas |
| glb_we_i | input | 1 | Global setting write strobe |
| glb_base_i | input | TIME_W | Operational base time |
| glb_last_i | input | THR_W | Active thread count minus one |
| gate_closed_o | output | N_PORT*8 | Closed gates, bit p*8+c |
| started_o | output | 1 | Schedule running |
| stopped_o | output | 1 | Engine stopped |
| wr_err_o | output | 1 | Write rejected while running |

## Verification
Status bits and the write error flag follow their cause by one clock. A stop clears the gates one clock after it is sampled. A thread's step lands on the clock that samples a boundary time T, and the gate pattern for that step appears one clock later. The gates are therefore valid from the cycle in which the time counter reads T+2. The bench drives the time counter itself, samples on the falling edge, and computes the expected pattern from the time value minus two. It does this with its own copy of the programmed table and a closed-form walk of each thread's slice, for directed and randomly drawn configurations and drift values.

// File: rtl/gsched_pkg.sv
package gsched_pkg;
    localparam int TC_N = 8;
    typedef logic [TC_N-1:0] tc_mask_t;

    // limit a signed tick correction to +/- lim
    function automatic int clamp_adj(input int a, input int lim);
        if (a > lim) return lim;
        if (a < -lim) return -lim;
        return a;
    endfunction
endpackage

// File: rtl/gsched_delta_gen.sv
module gsched_delta_gen
    import gsched_pkg::*;
#(
    parameter int TIME_W      = 32,
    parameter int ADJ_W       = 4,
    parameter int NOM_TICKS   = 25,
    parameter int MAX_ADJ     = 5,
    parameter int CORR_DELTAS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    stop_i,
    input  logic [TIME_W-1:0]       time_i,
    input  logic [TIME_W-1:0]       base_i,
    input  logic signed [ADJ_W-1:0] adj_i,
    output logic                    armed_o,
    output logic                    running_o,
    output logic                    bound_o
);
    localparam int DL_W  = $clog2(NOM_TICKS + MAX_ADJ + 1);
    localparam int CNT_W = $clog2(CORR_DELTAS + 1);

    typedef struct packed {
        logic             armed;
        logic             running;
        logic [DL_W-1:0]  tick;
        logic [DL_W-1:0]  dlen;
        logic [CNT_W-1:0] corr;
    } dg_t;

    dg_t             s_d, s_q;
    logic [DL_W-1:0] len_new_d;

    always_comb begin
        len_new_d = DL_W'(NOM_TICKS + clamp_adj(int'(adj_i), MAX_ADJ));
        s_d       = s_q;
        if (s_q.running) bound_o = (s_q.tick == s_q.dlen - 1'b1);
        else             bound_o = s_q.armed && (time_i >= base_i);

        if (stop_i) begin
            s_d.armed   = 1'b0;
            s_d.running = 1'b0;
            s_d.tick    = '0;
            s_d.corr    = '0;
        end else if (!s_q.armed) begin
            if (start_i) s_d.armed = 1'b1;
        end else if (bound_o) begin
            s_d.tick    = '0;
            s_d.running = 1'b1;
            if (!s_q.running || s_q.corr == CNT_W'(CORR_DELTAS - 1)) begin
                s_d.dlen = len_new_d;
                s_d.corr = '0;
            end else begin
                s_d.corr = s_q.corr + 1'b1;
            end
        end else if (s_q.running) begin
            s_d.tick = s_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.dlen <= DL_W'(NOM_TICKS);
        end else begin
            s_q <= s_d;
        end
    end

    assign armed_o   = s_q.armed;
    assign running_o = s_q.running;
endmodule

// File: rtl/gsched_thread.sv
module gsched_thread #(
    parameter int IDX_W = 4,
    parameter int DUR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             bound_i,
    input  logic             go_i,
    input  logic [IDX_W-1:0] entry_i,
    input  logic [IDX_W-1:0] end_i,
    input  logic [DUR_W-1:0] dur_entry_i,
    input  logic [DUR_W-1:0] dur_next_i,
    output logic             active_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [IDX_W-1:0] nxt_o
);
    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
        logic [DUR_W-1:0] left;
    } th_t;

    th_t s_d, s_q;

    function automatic logic [DUR_W-1:0] at_least_one(input logic [DUR_W-1:0] d);
        return (d == '0) ? DUR_W'(1) : d;
    endfunction

    always_comb begin
        nxt_o = (s_q.idx == end_i) ? entry_i : s_q.idx + 1'b1;
        s_d   = s_q;
        if (clear_i) begin
            s_d = '0;
        end else if (bound_i) begin
            if (!s_q.active) begin
                if (go_i) begin
                    s_d.active = 1'b1;
                    s_d.idx    = entry_i;
                    s_d.left   = at_least_one(dur_entry_i);
                end
            end else if (s_q.left <= DUR_W'(1)) begin
                s_d.idx  = nxt_o;
                s_d.left = at_least_one(dur_next_i);
            end else begin
                s_d.left = s_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active_o = s_q.active;
    assign idx_o    = s_q.idx;
endmodule

// File: rtl/gsched_merge.sv
module gsched_merge
    import gsched_pkg::*;
#(
    parameter int N_THR  = 8,
    parameter int N_PORT = 4
) (
    input  logic [N_THR-1:0]        act_i,
    input  logic [N_THR-1:0]        en_i,
    input  logic [N_THR*N_PORT-1:0] ports_i,
    input  logic [N_THR*TC_N-1:0]   closed_i,
    output logic [N_PORT*TC_N-1:0]  mask_o
);
    for (genvar p = 0; p < N_PORT; p++) begin : g_port
        tc_mask_t pick;
        always_comb begin
            pick = '0;
            // highest first so the lowest-numbered thread is written last
            for (int t = N_THR - 1; t >= 0; t--) begin
                if (act_i[t] && en_i[t] && ports_i[t*N_PORT+p])
                    pick = closed_i[t*TC_N +: TC_N];
            end
        end
        assign mask_o[p*TC_N +: TC_N] = pick;
    end
endmodule

// File: rtl/gsched_top.sv
module gsched_top
    import gsched_pkg::*;
#(
    parameter int N_THR       = 8,
    parameter int N_ENT       = 16,
    parameter int N_PORT      = 4,
    parameter int DUR_W       = 8,
    parameter int OFF_W       = 12,
    parameter int TIME_W      = 32,
    parameter int ADJ_W       = 4,
    parameter int NOM_TICKS   = 25,
    parameter int MAX_ADJ     = 5,
    parameter int CORR_DELTAS = 4,
    localparam int IDX_W      = $clog2(N_ENT),
    localparam int THR_W      = $clog2(N_THR),
    localparam int GATE_W     = N_PORT * TC_N
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [TIME_W-1:0]       time_i,
    input  logic signed [ADJ_W-1:0] adj_i,
    input  logic                    start_i,
    input  logic                    stop_i,
    input  logic                    tbl_we_i,
    input  logic [IDX_W-1:0]        tbl_addr_i,
    input  logic [DUR_W-1:0]        tbl_dur_i,
    input  logic [N_PORT-1:0]       tbl_ports_i,
    input  logic                    tbl_en_i,
    input  logic [TC_N-1:0]         tbl_closed_i,
    input  logic                    thr_we_i,
    input  logic [THR_W-1:0]        thr_sel_i,
    input  logic [IDX_W-1:0]        thr_entry_i,
    input  logic [IDX_W-1:0]        thr_end_i,
    input  logic [OFF_W-1:0]        thr_off_i,
    input  logic                    glb_we_i,
    input  logic [TIME_W-1:0]       glb_base_i,
    input  logic [THR_W-1:0]        glb_last_i,
    output logic [GATE_W-1:0]       gate_closed_o,
    output logic                    started_o,
    output logic                    stopped_o,
    output logic                    wr_err_o
);
    typedef struct packed {
        logic [DUR_W-1:0]  dur;
        logic [N_PORT-1:0] ports;
        logic              en;
        tc_mask_t          closed;
    } ent_t;

    typedef struct packed {
        logic [IDX_W-1:0] entry;
        logic [IDX_W-1:0] fin;
        logic [OFF_W-1:0] off;
    } thc_t;

    typedef struct packed {
        ent_t [N_ENT-1:0]  tbl;
        thc_t [N_THR-1:0]  thr;
        logic [TIME_W-1:0] base;
        logic [THR_W-1:0]  last_thr;
        logic              err;
        logic [GATE_W-1:0] gate;
    } top_t;

    top_t s_d, s_q;

    logic                    armed, running, bound;
    logic [N_THR-1:0]        act_v, en_v, go_v;
    logic [N_THR*N_PORT-1:0] ports_v;
    logic [N_THR*TC_N-1:0]   closed_v;
    logic [GATE_W-1:0]       merged;
    logic [TIME_W-1:0]       base_cur;

    assign base_cur = s_q.base;

    gsched_delta_gen #(
        .TIME_W(TIME_W), .ADJ_W(ADJ_W), .NOM_TICKS(NOM_TICKS),
        .MAX_ADJ(MAX_ADJ), .CORR_DELTAS(CORR_DELTAS)
    ) u_dgen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .time_i(time_i), .base_i(s_q.base), .adj_i(adj_i),
        .armed_o(armed), .running_o(running), .bound_o(bound)
    );

    for (genvar i = 0; i < N_THR; i++) begin : g_thr
        logic [IDX_W-1:0]  idx, nxt;
        logic [TIME_W-1:0] start_at;
        ent_t              cur;

        assign start_at = s_q.base + TIME_W'(s_q.thr[i].off) * TIME_W'(NOM_TICKS);
        assign go_v[i]  = (i <= int'(s_q.last_thr)) && (time_i >= start_at);
        assign cur      = s_q.tbl[idx];

        gsched_thread #(.IDX_W(IDX_W), .DUR_W(DUR_W)) u_thr (
            .clk(clk), .rst_n(rst_n), .clear_i(stop_i), .bound_i(bound),
            .go_i(go_v[i]), .entry_i(s_q.thr[i].entry), .end_i(s_q.thr[i].fin),
            .dur_entry_i(s_q.tbl[s_q.thr[i].entry].dur),
            .dur_next_i(s_q.tbl[nxt].dur),
            .active_o(act_v[i]), .idx_o(idx), .nxt_o(nxt)
        );

        assign en_v[i]                      = cur.en;
        assign ports_v[i*N_PORT +: N_PORT]  = cur.ports;
        assign closed_v[i*TC_N +: TC_N]     = cur.closed;
    end

    gsched_merge #(.N_THR(N_THR), .N_PORT(N_PORT)) u_merge (
        .act_i(act_v), .en_i(en_v), .ports_i(ports_v),
        .closed_i(closed_v), .mask_o(merged)
    );

    always_comb begin
        s_d = s_q;
        if (tbl_we_i || thr_we_i || glb_we_i) begin
            if (armed) begin
                s_d.err = 1'b1;
            end else begin
                if (tbl_we_i) begin
                    s_d.tbl[tbl_addr_i].dur    = tbl_dur_i;
                    s_d.tbl[tbl_addr_i].ports  = tbl_ports_i;
                    s_d.tbl[tbl_addr_i].en     = tbl_en_i;
                    s_d.tbl[tbl_addr_i].closed = tbl_closed_i;
                end
                if (thr_we_i) begin
                    s_d.thr[thr_sel_i].entry = thr_entry_i;
                    s_d.thr[thr_sel_i].fin   = thr_end_i;
                    s_d.thr[thr_sel_i].off   = thr_off_i;
                end
                if (glb_we_i) begin
                    s_d.base     = glb_base_i;
                    s_d.last_thr = glb_last_i;
                end
            end
        end
        if (start_i && !stop_i && !armed) s_d.err = 1'b0;
        s_d.gate = stop_i ? '0 : merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign gate_closed_o = s_q.gate;
    assign started_o     = running;
    assign stopped_o     = !armed;
    assign wr_err_o      = s_q.err;
endmodule

// File: rtl/gsched_chk.sv
module gsched_chk #(
    parameter int GATE_W = 32,
    parameter int TIME_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              stop_i,
    input logic              any_we,
    input logic [TIME_W-1:0] time_i,
    input logic [TIME_W-1:0] base_cur,
    input logic [GATE_W-1:0] gate_closed_o,
    input logic              started_o,
    input logic              stopped_o,
    input logic              wr_err_o
);
    assert_stop_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (gate_closed_o == '0) && stopped_o && !started_o);

    assert_idle_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stopped_o |=> gate_closed_o == '0);

    assert_start_time_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(started_o) |-> $past(time_i) >= $past(base_cur));

    assert_status_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(started_o && stopped_o));

    assert_reject_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (any_we && !stopped_o) |=> wr_err_o);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_err_o && !start_i) |=> wr_err_o);
endmodule

bind gsched_top gsched_chk #(.GATE_W(GATE_W), .TIME_W(TIME_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .any_we(tbl_we_i || thr_we_i || glb_we_i), .time_i(time_i),
    .base_cur(base_cur), .gate_closed_o(gate_closed_o),
    .started_o(started_o), .stopped_o(stopped_o), .wr_err_o(wr_err_o)
);

// File: tb/gsched_top_tb.sv
`timescale 1ns/1ps
module gsched_top_tb;
    localparam int NOM = 25;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       tcount = '0;
    logic signed [3:0] adj_i = '0;
    logic              start_i = 1'b0, stop_i = 1'b0;
    logic              tbl_we_i = 1'b0, tbl_en_i = 1'b0;
    logic [3:0]        tbl_addr_i = '0, tbl_ports_i = '0;
    logic [7:0]        tbl_dur_i = '0, tbl_closed_i = '0;
    logic              thr_we_i = 1'b0, glb_we_i = 1'b0;
    logic [2:0]        thr_sel_i = '0, glb_last_i = '0;
    logic [3:0]        thr_entry_i = '0, thr_end_i = '0;
    logic [11:0]       thr_off_i = '0;
    logic [31:0]       glb_base_i = '0;
    logic [31:0]       gate_closed_o;
    logic              started_o, stopped_o, wr_err_o;

    int checks = 0, errors = 0;
    int b_dur[16], b_ports[16], b_en[16], b_cl[16];
    int b_ent[8], b_end[8], b_off[8];
    int b_base = 0, b_last = 0, b_dlen = NOM;
    bit b_run = 0;

    always #10 clk = ~clk;
    always @(posedge clk) tcount <= tcount + 1;

    gsched_top u_dut (
        .clk(clk), .rst_n(rst_n), .time_i(tcount), .adj_i(adj_i),
        .start_i(start_i), .stop_i(stop_i),
        .tbl_we_i(tbl_we_i), .tbl_addr_i(tbl_addr_i), .tbl_dur_i(tbl_dur_i),
        .tbl_ports_i(tbl_ports_i), .tbl_en_i(tbl_en_i), .tbl_closed_i(tbl_closed_i),
        .thr_we_i(thr_we_i), .thr_sel_i(thr_sel_i), .thr_entry_i(thr_entry_i),
        .thr_end_i(thr_end_i), .thr_off_i(thr_off_i),
        .glb_we_i(glb_we_i), .glb_base_i(glb_base_i), .glb_last_i(glb_last_i),
        .gate_closed_o(gate_closed_o), .started_o(started_o),
        .stopped_o(stopped_o), .wr_err_o(wr_err_o)
    );

    function automatic int max1(int d);
        return (d == 0) ? 1 : d;
    endfunction

    function automatic int kstart(int off);
        return (off * NOM + b_dlen - 1) / b_dlen;
    endfunction

    function automatic int cur_entry(int th, int k);
        int len = 0;
        int r;
        int e;
        for (int x = b_ent[th]; x <= b_end[th]; x++) len += max1(b_dur[x]);
        r = (k - kstart(b_off[th])) % len;
        e = b_ent[th];
        while (r >= max1(b_dur[e])) begin
            r -= max1(b_dur[e]);
            e++;
        end
        return e;
    endfunction

    function automatic logic [31:0] exp_mask(int t);
        logic [31:0] m = '0;
        int eff = t - 2;
        int k;
        if (!b_run || eff < b_base) return '0;
        k = (eff - b_base) / b_dlen;
        for (int p = 0; p < 4; p++) begin
            bit done = 0;
            for (int th = 0; th <= b_last; th++) begin
                if (!done && k >= kstart(b_off[th])) begin
                    int e = cur_entry(th, k);
                    if (b_en[e] != 0 && b_ports[e][p]) begin
                        m[p*8 +: 8] = 8'(b_cl[e]);
                        done = 1;
                    end
                end
            end
        end
        return m;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h at time count %0d", tag, got, exp, tcount);
        end
    endtask

    task automatic wr_ent(int e, int d, int pm, int en, int cl, bit upd);
        @(negedge clk);
        tbl_we_i = 1'b1; tbl_addr_i = 4'(e); tbl_dur_i = 8'(d);
        tbl_ports_i = 4'(pm); tbl_en_i = en[0]; tbl_closed_i = 8'(cl);
        @(negedge clk);
        tbl_we_i = 1'b0;
        if (upd) begin b_dur[e] = d; b_ports[e] = pm; b_en[e] = en; b_cl[e] = cl; end
    endtask

    task automatic wr_thr(int t, int en_a, int fin, int off, bit upd);
        @(negedge clk);
        thr_we_i = 1'b1; thr_sel_i = 3'(t); thr_entry_i = 4'(en_a);
        thr_end_i = 4'(fin); thr_off_i = 12'(off);
        @(negedge clk);
        thr_we_i = 1'b0;
        if (upd) begin b_ent[t] = en_a; b_end[t] = fin; b_off[t] = off; end
    endtask

    // program base and thread count, then start with a given drift value
    task automatic go(int last, int adj);
        int c;
        c = (adj > 5) ? 5 : ((adj < -5) ? -5 : adj);
        adj_i = 4'(adj);
        b_dlen = NOM + c;
        b_last = last;
        @(negedge clk);
        b_base = int'(tcount) + 8;
        glb_we_i = 1'b1; glb_base_i = 32'(b_base); glb_last_i = 3'(last);
        @(negedge clk);
        glb_we_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        b_run = 1;
        check("R2 stopped after start", {31'b0, stopped_o}, 32'd0);
    endtask

    task automatic run(int n, string tag);
        repeat (n) begin
            @(negedge clk);
            check(tag, gate_closed_o, exp_mask(int'(tcount)));
            check("R2 started", {31'b0, started_o}, {31'b0, (int'(tcount) >= b_base + 1)});
        end
    endtask

    task automatic halt();
        @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        b_run = 0;
        check("R7 gates open", gate_closed_o, '0);
        check("R7 stopped", {30'b0, stopped_o, started_o}, 32'b10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7411));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check("R1 gates", gate_closed_o, '0);
        check("R1 status", {29'b0, stopped_o, started_o, wr_err_o}, 32'b100);

        // R5 R9: one thread, durations 1,0,3 (0 acts as 1), wraps
        wr_ent(0, 1, 4'hF, 1, 8'h11, 1);
        wr_ent(1, 0, 4'hF, 1, 8'h22, 1);
        wr_ent(2, 3, 4'h5, 1, 8'h44, 1);
        wr_thr(0, 0, 2, 1, 1);
        go(0, 0);
        run(300, "R5 single thread walk");
        halt();

        // R10 priority and R4 thread above last not running
        wr_ent(3, 2, 4'b0011, 1, 8'hA1, 1);
        wr_ent(4, 1, 4'b0011, 0, 8'hA2, 1);
        wr_ent(5, 3, 4'b0110, 1, 8'hB1, 1);
        wr_ent(6, 2, 4'b1110, 1, 8'hB2, 1);
        wr_ent(7, 1, 4'hF, 1, 8'hFF, 1);
        wr_thr(0, 3, 4, 1, 1);
        wr_thr(1, 5, 6, 2, 1);
        wr_thr(2, 7, 7, 0, 1);
        go(1, 0);
        run(400, "R10 lower thread wins");
        halt();
        go(2, 0);
        run(300, "R4 third thread offset zero");
        halt();

        // R3 drift stretch, clamp high, clamp low
        go(1, 3);
        run(300, "R3 delta of 28");
        halt();
        go(1, 7);
        run(300, "R3 clamp to 30");
        halt();
        go(1, -8);
        run(300, "R3 clamp to 20");
        halt();

        // R8 writes while running are ignored and flagged
        go(1, 0);
        run(40, "R8 before write");
        wr_thr(0, 7, 7, 0, 0);
        wr_ent(3, 9, 4'h0, 0, 8'h00, 0);
        check("R8 error flag", {31'b0, wr_err_o}, 32'd1);
        run(200, "R8 old schedule kept");
        halt();
        check("R8 flag sticky when stopped", {31'b0, wr_err_o}, 32'd1);
        @(negedge clk);
        stop_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0; start_i = 1'b0;
        check("R7 stop beats start", {31'b0, stopped_o}, 32'd1);
        go(1, 0);
        check("R8 flag cleared by start", {31'b0, wr_err_o}, 32'd0);
        run(60, "R6 after restart");
        halt();

        // random configurations
        for (int s = 0; s < 20; s++) begin
            int pos = 0;
            int last = int'($urandom % 4);
            for (int th = 0; th <= last; th++) begin
                int len = 1 + int'($urandom % 3);
                for (int e = pos; e < pos + len; e++)
                    wr_ent(e, int'($urandom % 4), int'($urandom % 16),
                           int'(($urandom % 4) != 0), int'($urandom % 256), 1);
                wr_thr(th, pos, pos + len - 1, int'($urandom % 6), 1);
                pos += len;
            end
            go(last, int'($urandom % 15) - 7);
            run(250, "R6 random schedule");
            halt();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule